// File: doc/BRIEF.md
# ECC Fault Injection Control Bank

This block is a small memory-mapped register bank that arms deliberate bit flips in a cache's ECC-protected storage. Software programs a flip mask, an optional start delay and a control word. Once the bank is armed, it presents an injection request to the cache. The request names the target array (tag or data), the array banks that are affected, and the XOR pattern to apply. The cache applies the pattern on its next access and answers with a one-cycle done pulse. The cache arrays, the ECC codecs and the bus fabric sit outside this block.

Arming can be immediate, or it can wait for a down-counter to run out. In the one-shot mode the enable bit clears itself once the cache takes the injection. In the persist mode the counter is loaded again with the delay that software last wrote, so the bank arms again after that many cycles. Registers are read combinationally on the same bus, with one 64-bit word in each 8-byte slot of a 128-byte window.

Top module: `ecc_inj_bank`

## Requirements
- R1: Address bits [6:3] pick a 64-bit word. Word 0 (offset 0x00) is control, word 1 (0x08) is the delay counter and word 2 (0x10) is the flip mask. Reading any other word gives zero, and writing it changes nothing. Read data follows the address in the same cycle.
- R2: The control word has enable at bit 0, persist at bit 1, delay-enable at bit 2, target at bit 3 (0 = tag, 1 = data) and bank select at bits [11:4]. The other bits read as zero. After reset every register is zero and inj_req is low.
- R3: With enable=1 and delay-enable=0, inj_req is high in the cycle after the control write.
- R4: With enable=1 and delay-enable=1, the counter drops by one on each clock until it reaches zero. inj_req rises when it is zero, exactly D cycles after the control write when D was written. The live count reads back at 0x08.
- R5: A done pulse while inj_req is high and persist=0 clears enable, and inj_req is low in the next cycle.
- R6: A done pulse while inj_req is high and persist=1 reloads the counter with the last delay written. With delay-enable set, the bank then arms again after that many cycles.
- R7: While armed, inj_mask carries the full mask when the target is data. When the target is tag, only mask bits [TAG_W-1:0] pass and the higher bits are zero.
- R8: While armed, inj_banks equals the bank select field and inj_target equals the target bit. While not armed, inj_mask, inj_banks and inj_target are zero.
- R9: A done pulse while inj_req is low changes no register.
- R10: A write to 0x08 sets both the live counter and the saved reload value. A control write in the same cycle as a done pulse takes precedence over the self-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| inj_done | input | 1 | One-cycle pulse from the cache when an injection was applied |
| inj_req | output | 1 | Injection armed |
| inj_target | output | 1 | 0 = tag array, 1 = data array |
| inj_banks | output | NBANK | Bank enable vector |
| inj_mask | output | MASK_W | XOR flip pattern |

## Verification
Register writes take effect at the clock edge that captures them, and read data is combinational. The bench therefore samples one time unit after each capturing edge, and it sets the read address before sampling. For a delay of D, inj_req is due D edges after the control write. The bench sweeps D from 0 to 6 and checks inj_req and the counter readback at every edge in between. A done pulse shows its effect one edge later, and the bench checks inj_req and the control readback there. All 256 bank-select values are checked at the edge after each write.

// File: rtl/ecc_inj_pkg.sv
`timescale 1ns/1ps
package ecc_inj_pkg;
   localparam int BANK_FIELD_W = 8;
   localparam int CTRL_W       = 4 + BANK_FIELD_W;

   localparam logic [3:0] WORD_CTRL  = 4'd0;
   localparam logic [3:0] WORD_DELAY = 4'd1;
   localparam logic [3:0] WORD_MASK  = 4'd2;

   typedef struct packed {
      logic [BANK_FIELD_W-1:0] bank;
      logic                    tgt_data;
      logic                    dly_en;
      logic                    persist;
      logic                    en;
   } inj_ctrl_t;
endpackage

// File: rtl/ecc_inj_ctrl.sv
`timescale 1ns/1ps
module ecc_inj_ctrl
   import ecc_inj_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int MASK_W = 64,
   parameter int NBANK  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_mask,
   input  logic [DATA_W-1:0] wdata,
   input  logic              fire,
   output inj_ctrl_t         ctrl,
   output logic [MASK_W-1:0] mask
);
   localparam logic [BANK_FIELD_W-1:0] BANK_KEEP =
      BANK_FIELD_W'((1 << NBANK) - 1);

   inj_ctrl_t ctrl_wr;

   always_comb begin
      ctrl_wr      = inj_ctrl_t'(wdata[CTRL_W-1:0]);
      ctrl_wr.bank = ctrl_wr.bank & BANK_KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ctrl) begin
         ctrl <= ctrl_wr;
      end else if (fire && !ctrl.persist) begin
         ctrl.en <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '0;
      end else if (wr_mask) begin
         mask <= wdata[MASK_W-1:0];
      end
   end
endmodule

// File: rtl/ecc_inj_delay.sv
`timescale 1ns/1ps
module ecc_inj_delay #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_delay,
   input  logic [DATA_W-1:0] wdata,
   input  logic             fire,
   input  logic             persist,
   input  logic             run,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] reload,
   output logic             expired
);
   assign expired = (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         reload <= '0;
      end else if (wr_delay) begin
         count  <= wdata[CNT_W-1:0];
         reload <= wdata[CNT_W-1:0];
      end else if (fire && persist) begin
         count <= reload;
      end else if (run && !expired) begin
         count <= count - CNT_W'(1);
      end
   end
endmodule

// File: rtl/ecc_inj_shape.sv
`timescale 1ns/1ps
module ecc_inj_shape #(
   parameter int MASK_W = 64,
   parameter int TAG_W  = 32,
   parameter int NBANK  = 8
) (
   input  logic              armed,
   input  logic              tgt_data,
   input  logic [NBANK-1:0]  bank_sel,
   input  logic [MASK_W-1:0] mask,
   output logic              inj_target,
   output logic [NBANK-1:0]  inj_banks,
   output logic [MASK_W-1:0] inj_mask
);
   logic [MASK_W-1:0] tag_view;

   generate
      if (TAG_W < MASK_W) begin : g_tag_trim
         assign tag_view = {{(MASK_W-TAG_W){1'b0}}, mask[TAG_W-1:0]};
      end else begin : g_tag_full
         assign tag_view = mask;
      end
   endgenerate

   always_comb begin
      inj_target = armed & tgt_data;
      inj_banks  = armed ? bank_sel : '0;
      if (!armed)        inj_mask = '0;
      else if (tgt_data) inj_mask = mask;
      else               inj_mask = tag_view;
   end
endmodule

// File: rtl/ecc_inj_bank.sv
`timescale 1ns/1ps
module ecc_inj_bank
   import ecc_inj_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 64,
   parameter int MASK_W = 64,
   parameter int CNT_W  = 64,
   parameter int TAG_W  = 32,
   parameter int NBANK  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              inj_done,
   output logic              inj_req,
   output logic              inj_target,
   output logic [NBANK-1:0]  inj_banks,
   output logic [MASK_W-1:0] inj_mask
);
   localparam int WORD_W = ADDR_W - 3;

   generate
      if (ADDR_W != 7)                      begin : g_bad_addr  $error("ADDR_W must be 7"); end
      if (NBANK < 1 || NBANK > BANK_FIELD_W) begin : g_bad_bank  $error("NBANK out of range"); end
      if (MASK_W > DATA_W || CNT_W > DATA_W) begin : g_bad_width $error("register wider than bus"); end
      if (TAG_W < 1 || TAG_W > MASK_W)       begin : g_bad_tag   $error("TAG_W out of range"); end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              wr_ctrl, wr_delay, wr_mask, fire;
   inj_ctrl_t         ctrl;
   logic [MASK_W-1:0] mask;
   logic [CNT_W-1:0]  count, reload;
   logic              expired;

   assign word     = bus_addr[ADDR_W-1:3];
   assign wr_ctrl  = bus_wr && (word == WORD_CTRL);
   assign wr_delay = bus_wr && (word == WORD_DELAY);
   assign wr_mask  = bus_wr && (word == WORD_MASK);

   assign inj_req = ctrl.en && (!ctrl.dly_en || expired);
   assign fire    = inj_done && inj_req;

   ecc_inj_ctrl #(.DATA_W(DATA_W), .MASK_W(MASK_W), .NBANK(NBANK)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_mask(wr_mask),
      .wdata(bus_wdata), .fire(fire), .ctrl(ctrl), .mask(mask)
   );

   ecc_inj_delay #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_delay (
      .clk(clk), .rst_n(rst_n), .wr_delay(wr_delay), .wdata(bus_wdata),
      .fire(fire), .persist(ctrl.persist), .run(ctrl.en && ctrl.dly_en),
      .count(count), .reload(reload), .expired(expired)
   );

   ecc_inj_shape #(.MASK_W(MASK_W), .TAG_W(TAG_W), .NBANK(NBANK)) u_shape (
      .armed(inj_req), .tgt_data(ctrl.tgt_data), .bank_sel(ctrl.bank[NBANK-1:0]),
      .mask(mask), .inj_target(inj_target), .inj_banks(inj_banks), .inj_mask(inj_mask)
   );

   always_comb begin
      bus_rdata = '0;
      case (word)
         WORD_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl;
         WORD_DELAY: bus_rdata[CNT_W-1:0]  = count;
         WORD_MASK:  bus_rdata[MASK_W-1:0] = mask;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ecc_inj_bank_chk.sv
`timescale 1ns/1ps
module ecc_inj_bank_chk
   import ecc_inj_pkg::*;
#(
   parameter int MASK_W = 64,
   parameter int CNT_W  = 64,
   parameter int TAG_W  = 32,
   parameter int NBANK  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              inj_done,
   input logic              inj_req,
   input logic              inj_target,
   input logic [NBANK-1:0]  inj_banks,
   input logic [MASK_W-1:0] inj_mask,
   input logic              wr_ctrl,
   input logic              wr_delay,
   input inj_ctrl_t         ctrl,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  reload
);
   // R5: one-shot self clear
   a_r5_oneshot_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_done && inj_req && !ctrl.persist && !wr_ctrl) |=> !inj_req);

   // R4: countdown by one
   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.en && ctrl.dly_en && count != '0 && !wr_delay && !(inj_done && inj_req))
      |=> (count == $past(count) - CNT_W'(1)));

   // R6: persist reload
   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_done && inj_req && ctrl.persist && !wr_delay) |=> (count == $past(reload)));

   // R7: tag target trims mask
   a_r7_tag_trim: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_req && !inj_target) |-> ((inj_mask >> TAG_W) == '0));

   // R8: quiet outputs when not armed
   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !inj_req |-> (inj_mask == '0 && inj_banks == '0 && !inj_target));

   // R9: ignored done leaves counter alone
   a_r9_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_done && !inj_req && !wr_delay && !(ctrl.en && ctrl.dly_en)) |=> $stable(count));
endmodule

bind ecc_inj_bank ecc_inj_bank_chk #(
   .MASK_W(MASK_W), .CNT_W(CNT_W), .TAG_W(TAG_W), .NBANK(NBANK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .inj_done(inj_done), .inj_req(inj_req),
   .inj_target(inj_target), .inj_banks(inj_banks), .inj_mask(inj_mask),
   .wr_ctrl(wr_ctrl), .wr_delay(wr_delay), .ctrl(ctrl), .count(count), .reload(reload)
);

// File: tb/sim_ecc_inj_bank.sv
`timescale 1ns/1ps
module sim_ecc_inj_bank;
   localparam int TAG_W = 32;
   localparam logic [6:0] A_CTRL = 7'h00, A_DLY = 7'h08, A_MASK = 7'h10, A_FREE = 7'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic        inj_done = 1'b0;
   logic        inj_req, inj_target;
   logic [7:0]  inj_banks;
   logic [63:0] inj_mask;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   ecc_inj_bank u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inj_done(inj_done),
      .inj_req(inj_req), .inj_target(inj_target), .inj_banks(inj_banks),
      .inj_mask(inj_mask)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [63:0] d, input logic with_done);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; inj_done = with_done;
      @(posedge clk); #1;
      bus_wr = 1'b0; inj_done = 1'b0;
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic pulse_done();
      @(negedge clk);
      inj_done = 1'b1;
      @(posedge clk); #1;
      inj_done = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [63:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   function automatic logic [63:0] ctl(input logic [7:0] bank, input logic tgt,
                                       input logic dly, input logic pst, input logic en);
      return {52'd0, bank, tgt, dly, pst, en};
   endfunction

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [63:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R2 reset state
      rd(A_CTRL, v); chk("R2 reset ctrl", v, 64'd0);
      rd(A_DLY,  v); chk("R2 reset delay", v, 64'd0);
      rd(A_MASK, v); chk("R2 reset mask", v, 64'd0);
      chk("R2 reset req", {63'd0, inj_req}, 64'd0);

      // R1 map and unmapped words
      wr(A_MASK, 64'hF0F0_1234_5678_9ABC, 1'b0);
      rd(A_MASK, v); chk("R1 mask readback", v, 64'hF0F0_1234_5678_9ABC);
      wr(A_FREE, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      rd(A_FREE, v); chk("R1 unmapped read zero", v, 64'd0);
      rd(A_MASK, v); chk("R1 unmapped write ignored", v, 64'hF0F0_1234_5678_9ABC);
      rd(A_CTRL, v); chk("R1 unmapped write ctrl", v, 64'd0);

      // R2 layout: unused bits read zero
      wr(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
      rd(A_CTRL, v); chk("R2 ctrl field width", v, 64'h0000_0000_0000_0FFE);
      wr(A_CTRL, 64'd0, 1'b0);

      // R3 immediate arm; R7/R8 exhaustive bank/target sweep
      wr(A_MASK, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      for (int b = 0; b < 256; b++) begin
         wr(A_CTRL, ctl(8'(b), b[0], 1'b0, 1'b1, 1'b1), 1'b0);
         chk("R3 immediate arm", {63'd0, inj_req}, 64'd1);
         chk("R8 bank select", {56'd0, inj_banks}, {56'd0, 8'(b)});
         chk("R8 target", {63'd0, inj_target}, {63'd0, b[0]});
         chk("R7 mask shaping", inj_mask,
             b[0] ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << TAG_W) - 64'd1));
      end
      wr(A_CTRL, 64'd0, 1'b0);
      chk("R8 quiet outputs", {inj_mask[7:0], inj_banks, 47'd0, inj_target}, 64'd0);

      // R4 delay sweep, R5 one-shot clear
      for (int d = 0; d <= 6; d++) begin
         wr(A_DLY, 64'(d), 1'b0);
         wr(A_CTRL, ctl(8'h5A, 1'b1, 1'b1, 1'b0, 1'b1), 1'b0);
         for (int k = 0; k <= d; k++) begin
            chk("R4 req timing", {63'd0, inj_req}, {63'd0, (k == d)});
            rd(A_DLY, v); chk("R4 live count", v, 64'(d - k));
            if (k < d) step();
         end
         pulse_done();
         chk("R5 req drops", {63'd0, inj_req}, 64'd0);
         rd(A_CTRL, v); chk("R5 enable cleared", v, 64'h5AC);
      end

      // R6 persist reload and re-arm
      wr(A_DLY, 64'd3, 1'b0);
      wr(A_CTRL, ctl(8'h01, 1'b0, 1'b1, 1'b1, 1'b1), 1'b0);
      repeat (3) step();
      chk("R6 armed first", {63'd0, inj_req}, 64'd1);
      pulse_done();
      rd(A_DLY, v); chk("R6 reload value", v, 64'd3);
      chk("R6 req low after reload", {63'd0, inj_req}, 64'd0);
      repeat (2) step();
      chk("R6 not yet rearmed", {63'd0, inj_req}, 64'd0);
      step();
      chk("R6 rearmed", {63'd0, inj_req}, 64'd1);
      rd(A_CTRL, v); chk("R6 enable kept", v, 64'h017);
      wr(A_CTRL, 64'd0, 1'b0);

      // R9 done ignored when idle
      wr(A_DLY, 64'd5, 1'b0);
      wr(A_CTRL, ctl(8'h02, 1'b0, 1'b1, 1'b0, 1'b0), 1'b0);
      pulse_done();
      rd(A_DLY, v);  chk("R9 counter untouched", v, 64'd5);
      rd(A_CTRL, v); chk("R9 ctrl untouched", v, 64'h024);
      chk("R9 req stays low", {63'd0, inj_req}, 64'd0);

      // R10 delay write sets reload; ctrl write beats self clear
      wr(A_DLY, 64'd2, 1'b0);
      wr(A_CTRL, ctl(8'h00, 1'b0, 1'b1, 1'b1, 1'b1), 1'b0);
      repeat (2) step();
      pulse_done();
      rd(A_DLY, v); chk("R10 reload from last write", v, 64'd2);
      wr(A_CTRL, ctl(8'h03, 1'b0, 1'b0, 1'b0, 1'b1), 1'b0);
      chk("R10 armed", {63'd0, inj_req}, 64'd1);
      wr(A_CTRL, ctl(8'h03, 1'b1, 1'b0, 1'b0, 1'b1), 1'b1);
      chk("R10 write wins over clear", {63'd0, inj_req}, 64'd1);
      rd(A_CTRL, v); chk("R10 ctrl value", v, 64'h039);

      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule